// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Replacement

The router takes the interrupt requests of a set of timer channels and two external legacy sources, a legacy periodic timer and a real-time-clock (RTC) interrupt, and steers them onto a bank of interrupt lines. In normal operation each channel that is in line mode drives the line selected by its route field. The two external sources pass through to their usual lines: the timer line and the RTC line. When legacy-replacement mode is requested, channel 0 takes over the timer line and channel 1 takes over the RTC line, and the external sources are masked. The RTC input level is still recorded while it is masked, so it can be put back on its line when the mode ends.

Entering and leaving legacy-replacement mode follows a fixed sequence, run by the mode state machine. The states are LM_NORMAL, LM_ENTER, LM_LEGACY and LM_EXIT. A request raised in LM_NORMAL moves to LM_ENTER. LM_ENTER always moves to LM_LEGACY after one cycle. Dropping the request in LM_LEGACY moves to LM_EXIT. LM_EXIT always returns to LM_NORMAL after one cycle. The legacy-timer gate output is high in LM_NORMAL and LM_EXIT.

A channel can be switched to message delivery. It then drives no line. Each rising edge of its request queues one message write, whose address and data come from that channel's 64-bit message word. The message state machine has two states. MS_IDLE grants the lowest-numbered pending channel and moves to MS_SEND. MS_SEND holds the valid output until the receiver accepts the write, then returns to MS_IDLE. Only one message is outstanding at a time. The timing logic of the channels and the register bus that programs them are outside this block.

Top module: `legacy_irq_router`

## Requirements
- R1: After reset, every interrupt line is low, `timer_gate` is high, `msg_valid` is low, and the mode state machine is in LM_NORMAL.
- R2: In LM_NORMAL, a channel with its request high and message delivery off drives line `route` one cycle later. The route field of channel i is bits `[i*RW +: RW]` of `chan_route`. A route value at or above NUM_LINES drives no line.
- R3: In LM_NORMAL, `irq_line[TIMER_LINE]` follows `ext_timer_irq` and `irq_line[RTC_LINE]` follows `ext_rtc_irq`, each one cycle later.
- R4: In LM_LEGACY, channel 0 drives TIMER_LINE and channel 1 drives RTC_LINE whatever their route fields hold, and neither external source reaches any line.
- R5: In the LM_ENTER cycle, `timer_gate` is low and lines TIMER_LINE and RTC_LINE are both held low.
- R6: In the LM_EXIT cycle, `timer_gate` is high, line TIMER_LINE is low, and line RTC_LINE carries the RTC level recorded on the previous clock.
- R7: The RTC input level is recorded on every clock, including while legacy mode masks it.
- R8: With message delivery on, a rising request edge produces exactly one message. Its `msg_addr` is bits [63:32] of the channel's word in `chan_msg_word` (bits `[i*64 +: 64]`), its `msg_data` is bits [31:0], and no line is driven by that channel.
- R9: Turning message delivery on for a channel whose request is high removes its line contribution one cycle later, without queuing a message.
- R10: `msg_valid` stays high with `msg_addr` and `msg_data` unchanged until `msg_ready` is high. Only one message is outstanding. When several are pending, the lowest channel number is sent first.
- R11: Lines driven by several channels are the OR of their requests. Channels numbered 2 and above keep their route fields in every mode state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| legacy_mode | input | 1 | Request for legacy-replacement mode |
| ext_timer_irq | input | 1 | External legacy timer interrupt level |
| ext_rtc_irq | input | 1 | External RTC interrupt level |
| chan_req | input | NUM_CHAN | Interrupt request level of each channel |
| chan_msg_en | input | NUM_CHAN | Message delivery enable of each channel |
| chan_route | input | NUM_CHAN*RW | Line route field of each channel, RW = clog2(NUM_LINES) |
| chan_msg_word | input | NUM_CHAN*64 | Message address (upper 32 bits) and data (lower 32 bits) of each channel |
| msg_ready | input | 1 | Receiver accepts the message write |
| irq_line | output | NUM_LINES | Interrupt line bank |
| timer_gate | output | 1 | Enable for the external legacy timer |
| msg_valid | output | 1 | Message write is presented |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The bench builds the router with three channels and twelve lines, so the route field is four bits wide. Route values 12 to 15 can therefore be driven to check that out-of-range routes are dropped. Channel 2 stays outside the legacy takeover, which exercises the rule that higher channels keep their routes in legacy mode. With only three channels, simultaneous message requests and the lowest-first grant order come up often in the randomised phase. With the RTC line at 8, the takeover lines stay clear of the route values used by the directed cases.

// File: rtl/legacy_irq_router_pkg.sv
package legacy_irq_router_pkg;

    typedef enum logic [1:0] {
        LM_NORMAL = 2'd0,
        LM_ENTER  = 2'd1,
        LM_LEGACY = 2'd2,
        LM_EXIT   = 2'd3
    } lm_state_t;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_SEND = 1'b1
    } ms_state_t;

    localparam int MSG_WORD_W = 64;
    localparam int MSG_HALF_W = MSG_WORD_W / 2;

endpackage

// File: rtl/legacy_irq_router_mode.sv
module legacy_irq_router_mode
    import legacy_irq_router_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      legacy_mode,
    input  logic      ext_rtc_irq,
    output lm_state_t mode_state,
    output logic      rtc_held,
    output logic      timer_gate
);

    lm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LM_NORMAL: if (legacy_mode)  state_d = LM_ENTER;
            LM_ENTER:                    state_d = LM_LEGACY;
            LM_LEGACY: if (!legacy_mode) state_d = LM_EXIT;
            LM_EXIT:                     state_d = LM_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= LM_NORMAL;
            rtc_held <= 1'b0;
        end else begin
            state_q  <= state_d;
            rtc_held <= ext_rtc_irq;
        end
    end

    always_comb begin
        mode_state = state_q;
        unique case (state_q)
            LM_NORMAL, LM_EXIT:  timer_gate = 1'b1;
            LM_ENTER, LM_LEGACY: timer_gate = 1'b0;
        endcase
    end

endmodule

// File: rtl/legacy_irq_router_steer.sv
module legacy_irq_router_steer
    import legacy_irq_router_pkg::*;
#(
    parameter int NUM_CHAN   = 3,
    parameter int NUM_LINES  = 24,
    parameter int TIMER_LINE = 0,
    parameter int RTC_LINE   = 8,
    localparam int RW        = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  lm_state_t              mode_state,
    input  logic                   rtc_held,
    input  logic                   ext_timer_irq,
    input  logic                   ext_rtc_irq,
    input  logic [NUM_CHAN-1:0]    chan_req,
    input  logic [NUM_CHAN-1:0]    chan_msg_en,
    input  logic [NUM_CHAN*RW-1:0] chan_route,
    output logic [NUM_LINES-1:0]   irq_line
);

    logic [RW-1:0]        route [NUM_CHAN];
    logic [NUM_CHAN-1:0]  line_active;
    logic                 takeover;
    logic [NUM_LINES-1:0] routed;
    logic [NUM_LINES-1:0] line_d;

    assign line_active = chan_req & ~chan_msg_en;
    assign takeover    = (mode_state == LM_ENTER) || (mode_state == LM_LEGACY);

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_route
        assign route[c] = chan_route[c*RW +: RW];
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        always_comb begin
            routed[k] = 1'b0;
            for (int i = 0; i < NUM_CHAN; i++) begin
                if (line_active[i]) begin
                    if (takeover && i < 2) begin
                        if ((i == 0 && k == TIMER_LINE) || (i == 1 && k == RTC_LINE))
                            routed[k] = 1'b1;
                    end else if (route[i] == RW'(k)) begin
                        routed[k] = 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        line_d = routed;
        unique case (mode_state)
            LM_NORMAL: begin
                line_d[TIMER_LINE] = routed[TIMER_LINE] | ext_timer_irq;
                line_d[RTC_LINE]   = routed[RTC_LINE] | ext_rtc_irq;
            end
            LM_ENTER: begin
                line_d[TIMER_LINE] = 1'b0;
                line_d[RTC_LINE]   = 1'b0;
            end
            LM_LEGACY: ;
            LM_EXIT: begin
                line_d[TIMER_LINE] = 1'b0;
                line_d[RTC_LINE]   = rtc_held;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_line <= '0;
        else        irq_line <= line_d;
    end

endmodule

// File: rtl/legacy_irq_router_msg.sv
module legacy_irq_router_msg
    import legacy_irq_router_pkg::*;
#(
    parameter int NUM_CHAN = 3,
    localparam int CW      = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CHAN-1:0]            chan_req,
    input  logic [NUM_CHAN-1:0]            chan_msg_en,
    input  logic [NUM_CHAN*MSG_WORD_W-1:0] chan_msg_word,
    input  logic                           msg_ready,
    output logic                           msg_valid,
    output logic [MSG_HALF_W-1:0]          msg_addr,
    output logic [MSG_HALF_W-1:0]          msg_data
);

    ms_state_t             state_q, state_d;
    logic [NUM_CHAN-1:0]   req_q;
    logic [NUM_CHAN-1:0]   pending_q;
    logic [NUM_CHAN-1:0]   rise;
    logic [NUM_CHAN-1:0]   grant;
    logic [CW-1:0]         sel;
    logic                  take;
    logic [MSG_WORD_W-1:0] word [NUM_CHAN];

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_word
        assign word[c] = chan_msg_word[c*MSG_WORD_W +: MSG_WORD_W];
    end

    assign rise = chan_req & ~req_q & chan_msg_en;

    always_comb begin
        sel = '0;
        for (int i = NUM_CHAN - 1; i >= 0; i--) begin
            if (pending_q[i]) sel = CW'(i);
        end
    end

    assign take  = (state_q == MS_IDLE) && (|pending_q);
    assign grant = take ? (NUM_CHAN'(1) << sel) : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: if (take)      state_d = MS_SEND;
            MS_SEND: if (msg_ready) state_d = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= MS_IDLE;
            req_q     <= '0;
            pending_q <= '0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else begin
            state_q   <= state_d;
            req_q     <= chan_req;
            pending_q <= (pending_q & ~grant) | rise;
            if (take) begin
                msg_addr <= word[sel][MSG_WORD_W-1:MSG_HALF_W];
                msg_data <= word[sel][MSG_HALF_W-1:0];
            end
        end
    end

    always_comb begin
        unique case (state_q)
            MS_IDLE: msg_valid = 1'b0;
            MS_SEND: msg_valid = 1'b1;
        endcase
    end

endmodule

// File: rtl/legacy_irq_router.sv
module legacy_irq_router
    import legacy_irq_router_pkg::*;
#(
    parameter int NUM_CHAN   = 3,
    parameter int NUM_LINES  = 24,
    parameter int TIMER_LINE = 0,
    parameter int RTC_LINE   = 8,
    localparam int RW        = $clog2(NUM_LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    legacy_mode,
    input  logic                    ext_timer_irq,
    input  logic                    ext_rtc_irq,
    input  logic [NUM_CHAN-1:0]     chan_req,
    input  logic [NUM_CHAN-1:0]     chan_msg_en,
    input  logic [NUM_CHAN*RW-1:0]  chan_route,
    input  logic [NUM_CHAN*64-1:0]  chan_msg_word,
    input  logic                    msg_ready,
    output logic [NUM_LINES-1:0]    irq_line,
    output logic                    timer_gate,
    output logic                    msg_valid,
    output logic [31:0]             msg_addr,
    output logic [31:0]             msg_data
);

    lm_state_t mode_state;
    logic      rtc_held;

    legacy_irq_router_mode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .legacy_mode (legacy_mode),
        .ext_rtc_irq (ext_rtc_irq),
        .mode_state  (mode_state),
        .rtc_held    (rtc_held),
        .timer_gate  (timer_gate)
    );

    legacy_irq_router_steer #(
        .NUM_CHAN   (NUM_CHAN),
        .NUM_LINES  (NUM_LINES),
        .TIMER_LINE (TIMER_LINE),
        .RTC_LINE   (RTC_LINE)
    ) u_steer (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_state    (mode_state),
        .rtc_held      (rtc_held),
        .ext_timer_irq (ext_timer_irq),
        .ext_rtc_irq   (ext_rtc_irq),
        .chan_req      (chan_req),
        .chan_msg_en   (chan_msg_en),
        .chan_route    (chan_route),
        .irq_line      (irq_line)
    );

    legacy_irq_router_msg #(
        .NUM_CHAN (NUM_CHAN)
    ) u_msg (
        .clk           (clk),
        .rst_n         (rst_n),
        .chan_req      (chan_req),
        .chan_msg_en   (chan_msg_en),
        .chan_msg_word (chan_msg_word),
        .msg_ready     (msg_ready),
        .msg_valid     (msg_valid),
        .msg_addr      (msg_addr),
        .msg_data      (msg_data)
    );

endmodule

// File: rtl/legacy_irq_router_chk.sv
module legacy_irq_router_chk #(
    parameter int NUM_CHAN   = 3,
    parameter int NUM_LINES  = 24,
    parameter int TIMER_LINE = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 legacy_mode,
    input logic                 ext_timer_irq,
    input logic [NUM_CHAN-1:0]  chan_req,
    input logic                 msg_ready,
    input logic [NUM_LINES-1:0] irq_line,
    input logic                 timer_gate,
    input logic                 msg_valid,
    input logic [31:0]          msg_addr,
    input logic [31:0]          msg_data
);

    // R5: a legacy request held over two clocks leaves the legacy timer gated off
    assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(legacy_mode) && $past(legacy_mode, 2)) |-> !timer_gate);

    // R6: a normal-mode request held over two clocks leaves the legacy timer enabled
    assert_gate_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(legacy_mode) && !$past(legacy_mode, 2)) |-> timer_gate);

    // R3: settled normal mode with no channel request copies the timer input
    assert_timer_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(legacy_mode) && !$past(legacy_mode, 2) && !$past(legacy_mode, 3)
         && !$past(legacy_mode, 4) && ($past(chan_req) == '0))
        |-> (irq_line[TIMER_LINE] == $past(ext_timer_irq)));

    // R10: an unaccepted message stays presented
    assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid);

    // R10: payload of an unaccepted message does not move
    assert_msg_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> ($stable(msg_addr) && $stable(msg_data)));

endmodule

bind legacy_irq_router legacy_irq_router_chk #(
    .NUM_CHAN   (NUM_CHAN),
    .NUM_LINES  (NUM_LINES),
    .TIMER_LINE (TIMER_LINE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .legacy_mode   (legacy_mode),
    .ext_timer_irq (ext_timer_irq),
    .chan_req      (chan_req),
    .msg_ready     (msg_ready),
    .irq_line      (irq_line),
    .timer_gate    (timer_gate),
    .msg_valid     (msg_valid),
    .msg_addr      (msg_addr),
    .msg_data      (msg_data)
);

// File: tb/legacy_irq_router_tb.sv
`timescale 1ns/1ps
module legacy_irq_router_tb;

    localparam int NC = 3;
    localparam int NL = 12;
    localparam int RW = 4;
    localparam int TL = 0;
    localparam int RL = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           legacy_mode = 1'b0;
    logic           ext_timer_irq = 1'b0;
    logic           ext_rtc_irq = 1'b0;
    logic [NC-1:0]  chan_req = '0;
    logic [NC-1:0]  chan_msg_en = '0;
    logic [NC*RW-1:0] chan_route = '0;
    logic [NC*64-1:0] chan_msg_word = '0;
    logic           msg_ready = 1'b0;
    logic [NL-1:0]  irq_line;
    logic           timer_gate;
    logic           msg_valid;
    logic [31:0]    msg_addr;
    logic [31:0]    msg_data;

    always #4 clk = ~clk;

    legacy_irq_router #(.NUM_CHAN(NC), .NUM_LINES(NL), .TIMER_LINE(TL), .RTC_LINE(RL)) u_dut (
        .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
        .ext_timer_irq(ext_timer_irq), .ext_rtc_irq(ext_rtc_irq),
        .chan_req(chan_req), .chan_msg_en(chan_msg_en), .chan_route(chan_route),
        .chan_msg_word(chan_msg_word), .msg_ready(msg_ready),
        .irq_line(irq_line), .timer_gate(timer_gate), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";
    bit finished = 0;

    // reference model state: phase 0 normal, 1 entering, 2 legacy, 3 leaving
    int        ph = 0;
    bit        rtc_seen = 0;
    bit [NC-1:0] req_seen = '0;
    bit [NC-1:0] pend = '0;
    bit        busy = 0;
    bit [31:0] m_addr = '0;
    bit [31:0] m_data = '0;
    bit [NL-1:0] m_line = '0;
    int        sent = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; rtc_seen = 0; req_seen = '0; pend = '0; busy = 0;
            m_addr = '0; m_data = '0; m_line = '0;
        end else begin
            bit [NL-1:0] nl;
            nl = '0;
            for (int c = 0; c < NC; c++) begin
                if (chan_req[c] && !chan_msg_en[c]) begin
                    int tgt;
                    if ((ph == 1 || ph == 2) && c < 2) tgt = (c == 0) ? TL : RL;
                    else tgt = int'(chan_route[c*RW +: RW]);
                    if (tgt < NL) nl[tgt] = 1'b1;
                end
            end
            if (ph == 0) begin nl[TL] = nl[TL] | ext_timer_irq; nl[RL] = nl[RL] | ext_rtc_irq; end
            if (ph == 1) begin nl[TL] = 1'b0; nl[RL] = 1'b0; end
            if (ph == 3) begin nl[TL] = 1'b0; nl[RL] = rtc_seen; end
            if (busy) begin
                if (msg_ready) busy = 0;
            end else begin
                for (int c = 0; c < NC; c++) begin
                    if (pend[c] && !busy) begin
                        busy = 1;
                        pend[c] = 1'b0;
                        m_addr = chan_msg_word[c*64+32 +: 32];
                        m_data = chan_msg_word[c*64 +: 32];
                        sent++;
                    end
                end
            end
            for (int c = 0; c < NC; c++)
                if (chan_req[c] && !req_seen[c] && chan_msg_en[c]) pend[c] = 1'b1;
            case (ph)
                0: ph = legacy_mode ? 1 : 0;
                1: ph = 2;
                2: ph = legacy_mode ? 2 : 3;
                default: ph = 0;
            endcase
            rtc_seen = ext_rtc_irq;
            req_seen = chan_req;
            m_line = nl;
        end
    end

    task automatic compare();
        bit exp_gate;
        bit bad;
        exp_gate = (ph == 0 || ph == 3);
        bad = (irq_line !== m_line) || (timer_gate !== exp_gate) || (msg_valid !== busy)
              || (busy && ((msg_addr !== m_addr) || (msg_data !== m_data)));
        vectors++;
        if (bad) begin
            miscompares++;
            $display("FAIL %s: lines=%h gate=%b valid=%b addr=%h data=%h expected lines=%h gate=%b valid=%b addr=%h data=%h",
                     cur_req, irq_line, timer_gate, msg_valid, msg_addr, msg_data,
                     m_line, exp_gate, busy, m_addr, m_data);
        end
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic set_route(input int c, input int r);
        chan_route[c*RW +: RW] = RW'(r);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(irq_line == '0, "R1", irq_line, 0);
        chk(timer_gate == 1'b1, "R1", timer_gate, 1);
        chk(msg_valid == 1'b0, "R1", msg_valid, 0);
        rst_n = 1'b1;
        tick(2);

        cur_req = "R3";
        ext_timer_irq = 1; tick();
        chk(irq_line[TL] == 1, "R3", irq_line[TL], 1);
        ext_rtc_irq = 1; tick();
        chk(irq_line[RL] == 1, "R3", irq_line[RL], 1);
        ext_timer_irq = 0; ext_rtc_irq = 0; tick(2);

        cur_req = "R2";
        set_route(0, 3); set_route(1, 6); set_route(2, 5);
        chan_req = 3'b101; tick();
        chk(irq_line == 12'h028, "R2", irq_line, 12'h028);
        set_route(2, 13); tick();
        chk(irq_line == 12'h008, "R2", irq_line, 12'h008);

        cur_req = "R11";
        set_route(2, 6); chan_req = 3'b110; tick();
        chk(irq_line == 12'h040, "R11", irq_line, 12'h040);
        chan_req = 3'b100; tick();
        chk(irq_line == 12'h040, "R11", irq_line, 12'h040);
        chan_req = '0; set_route(2, 4); tick();

        cur_req = "R5";
        ext_timer_irq = 1; ext_rtc_irq = 1; chan_req = 3'b101;
        legacy_mode = 1; tick();
        tick();
        chk(timer_gate == 0, "R5", timer_gate, 0);
        chk(irq_line[TL] == 0 && irq_line[RL] == 0, "R5", irq_line, 12'h010);

        cur_req = "R4";
        tick();
        chk(irq_line == 12'h011, "R4", irq_line, 12'h011);
        chan_req = 3'b110; ext_timer_irq = 1; tick();
        chk(irq_line == 12'h110, "R4", irq_line, 12'h110);
        cur_req = "R11";
        chk(irq_line[4] == 1, "R11", irq_line[4], 1);

        cur_req = "R7";
        chan_req = '0; ext_rtc_irq = 0; tick();
        ext_rtc_irq = 1; tick();
        chk(irq_line[RL] == 0, "R7", irq_line[RL], 0);

        cur_req = "R6";
        legacy_mode = 0; tick();
        tick();
        chk(timer_gate == 1, "R6", timer_gate, 1);
        chk(irq_line[TL] == 0 && irq_line[RL] == 1, "R6", irq_line, 12'h100);
        tick();
        ext_timer_irq = 0; ext_rtc_irq = 0; tick(2);

        cur_req = "R8";
        chan_msg_word[2*64 +: 64] = 64'hA5A5_0F00_1234_5678;
        set_route(2, 5);
        chan_msg_en = 3'b100; chan_req = 3'b100; tick();
        tick();
        chk(msg_valid == 1 && msg_addr == 32'hA5A5_0F00 && msg_data == 32'h1234_5678, "R8", msg_addr, 32'hA5A5_0F00);
        chk(irq_line[5] == 0, "R8", irq_line[5], 0);
        cur_req = "R10";
        tick(3);
        chk(msg_valid == 1, "R10", msg_valid, 1);
        msg_ready = 1; tick();
        chk(msg_valid == 0, "R10", msg_valid, 0);
        tick(2);
        cur_req = "R8";
        chk(sent == 1 && msg_valid == 0, "R8", sent, 1);
        msg_ready = 0; chan_req = '0; tick();

        cur_req = "R10";
        chan_msg_word[0 +: 64]  = 64'h0000_1000_0000_00AA;
        chan_msg_word[64 +: 64] = 64'h0000_2000_0000_00BB;
        chan_msg_en = 3'b011; chan_req = 3'b011; tick();
        tick();
        chk(msg_data == 32'h0000_00AA, "R10", msg_data, 32'hAA);
        msg_ready = 1; tick();
        msg_ready = 0; tick();
        chk(msg_valid == 1 && msg_data == 32'h0000_00BB, "R10", msg_data, 32'hBB);
        msg_ready = 1; tick(2);
        msg_ready = 0; chan_req = '0; chan_msg_en = '0; tick();

        cur_req = "R9";
        set_route(1, 6); chan_req = 3'b010; tick();
        chk(irq_line[6] == 1, "R9", irq_line[6], 1);
        chan_msg_en = 3'b010; tick();
        chk(irq_line[6] == 0, "R9", irq_line[6], 0);
        tick(2);
        chk(msg_valid == 0, "R9", msg_valid, 0);
        chan_req = '0; chan_msg_en = '0; tick();

        cur_req = "R2";
        for (int n = 0; n < 600; n++) begin
            chan_req      = NC'($urandom);
            chan_msg_en   = NC'($urandom) & NC'($urandom);
            chan_route    = (NC*RW)'($urandom);
            chan_msg_word = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            ext_timer_irq = 1'($urandom);
            ext_rtc_irq   = 1'($urandom);
            msg_ready     = 1'($urandom);
            if (($urandom % 16) == 0) legacy_mode = ~legacy_mode;
            tick();
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule